// File: doc/BRIEF.md
# Processor Status Word with Banked Stack Pointer

This block keeps a processor's status state in registers and shows it in two ways: as separate byte-wide fields, and as one packed 32-bit status word. The state is six condition flags (carry, overflow, zero, negative, interrupt enable, stack select), three system-control bits (trace and two step-division bits) and a 5-bit interrupt level. The block also owns the live stack pointer, which is general register 15, together with one banked copy for user mode and one for system mode.

When the stack-select flag changes, the live pointer and the banked copies swap in the same clock edge. Depending on the flag, each of the user and system stack-pointer ports reaches either the live register or its own banked storage. The interrupt level has a one-way floor: once it is 16 or higher, a write cannot lower it below 16. Any write, from any port, becomes visible on the read ports from the first clock edge after it is presented. All read ports are combinational views of the stored state.

Top module: `status_stack_unit`

## Requirements
- R1: While reset is low, and at the first clock after it is released, all flags and control bits are 0, the level is 15 (status word 0x000F0000), and the live pointer and both banked pointers read 0.
- R2: A flag-byte write keeps bits 5:0 as carry(0), overflow(1), zero(2), negative(3), interrupt enable(4) and stack select(5). The flag byte reads back with bits 7:6 at zero.
- R3: A control-byte write keeps bits 2:0 as trace(0), D0(1) and D1(2). The control byte reads back with bits 7:3 at zero.
- R4: The status word reads flags in bits 5:0, control in bits 10:8 and level in bits 20:16. Every other bit reads as zero.
- R5: A status-word write loads the flags from bits 5:0, the control bits from bits 10:8 and the level from bits 20:16. In the same cycle it overrides any flag, control or level port write.
- R6: A level write, whether from the level port or from the status word, stores the 5-bit value unchanged, except that a value below 16 arriving while the stored level is 16 or more is stored plus 16.
- R7: When stack select goes from 0 to 1, the system banked pointer takes the old live pointer and the live pointer takes the user banked pointer.
- R8: When stack select goes from 1 to 0, the user banked pointer takes the old live pointer and the live pointer takes the system banked pointer.
- R9: Writing stack select with its current value leaves all three stack pointers unchanged.
- R10: With select 0, the system pointer port reads and writes the live register and the user port uses its banked copy. With select 1, the user pointer port aliases the live register and the system port uses its banked copy.
- R11: In a cycle where a swap happens, all stack-pointer port writes are dropped. When both the register-15 port and the aliased mode port write the live register, the register-15 port wins.
- R12: A write presented before a clock edge does not change any read port until that edge, and is visible on every read port right after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Status-word write enable |
| sw_wdata | input | 32 | Status-word write data |
| sw_rdata | output | 32 | Packed status word |
| cc_we | input | 1 | Flag-byte write enable |
| cc_wdata | input | 8 | Flag-byte write data |
| cc_rdata | output | 8 | Flag byte |
| ctl_we | input | 1 | Control-byte write enable |
| ctl_wdata | input | 8 | Control-byte write data |
| ctl_rdata | output | 8 | Control byte |
| lvl_we | input | 1 | Interrupt-level write enable |
| lvl_wdata | input | 5 | Interrupt-level write data |
| sp_we | input | 1 | Register-15 write enable |
| sp_wdata | input | SP_W | Register-15 write data |
| sp_rdata | output | SP_W | Live stack pointer |
| usp_we | input | 1 | User pointer write enable |
| usp_wdata | input | SP_W | User pointer write data |
| usp_rdata | output | SP_W | User stack pointer |
| ssp_we | input | 1 | System pointer write enable |
| ssp_wdata | input | SP_W | System pointer write data |
| ssp_rdata | output | SP_W | System stack pointer |

## Verification
Each result passes through exactly one register: the fields, the level, the swap and the pointer writes all take effect at the first rising edge after the stimulus. The bench applies inputs on the falling edge and compares every read port one time unit after the next rising edge against a model that is updated once per step. For the timing requirement it also samples the outputs between applying the stimulus and the edge, to confirm that nothing has changed yet. The level floor is swept over every pair of stored and written values, each pair starting from a fresh reset. The flag and control bytes are each swept over all 256 values, with stack-pointer writes mixed in to cover swaps in both directions.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  localparam int SW_W    = 32;
  localparam int BYTE_W  = 8;
  localparam int CC_W    = 6;
  localparam int CTL_W   = 3;
  localparam int LVL_W   = 5;
  localparam int CTL_LSB = 8;
  localparam int LVL_LSB = 16;
  localparam int SEL_BIT = 5;

  localparam logic [LVL_W-1:0] LVL_RST  = LVL_W'(15);
  localparam logic [LVL_W-1:0] LVL_HALF = LVL_W'(1) << (LVL_W - 1);

  function automatic logic [SW_W-1:0] pack_word(
    input logic [CC_W-1:0]  cc,
    input logic [CTL_W-1:0] ctl,
    input logic [LVL_W-1:0] lvl
  );
    logic [SW_W-1:0] w;
    w = '0;
    w[CC_W-1:0]           = cc;
    w[CTL_LSB +: CTL_W]   = ctl;
    w[LVL_LSB +: LVL_W]   = lvl;
    return w;
  endfunction
endpackage

// File: rtl/ssu_field.sv
module ssu_field
  import ssu_pkg::*;
#(
  parameter int W   = 6,
  parameter int LSB = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_we,
  input  logic [SW_W-1:0]   word_wdata,
  input  logic              byte_we,
  input  logic [BYTE_W-1:0] byte_wdata,
  output logic [W-1:0]      fld_d,
  output logic [W-1:0]      fld_q
);
  logic fld_en;
  logic unused_bits;

  assign unused_bits = ^{word_wdata, byte_wdata};

  always_comb begin
    fld_en = 1'b0;
    fld_d  = fld_q;
    if (word_we) begin
      fld_en = 1'b1;
      fld_d  = word_wdata[LSB +: W];
    end else if (byte_we) begin
      fld_en = 1'b1;
      fld_d  = byte_wdata[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fld_q <= '0;
    else if (fld_en) fld_q <= fld_d;
  end
endmodule

// File: rtl/ssu_level.sv
module ssu_level
  import ssu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_we,
  input  logic [LVL_W-1:0] word_lvl,
  input  logic             lvl_we,
  input  logic [LVL_W-1:0] lvl_wdata,
  output logic [LVL_W-1:0] lvl_q
);
  logic             lvl_en;
  logic [LVL_W-1:0] cand;
  logic [LVL_W-1:0] lvl_d;
  logic             locked;

  always_comb begin
    lvl_en = word_we | lvl_we;
    cand   = word_we ? word_lvl : lvl_wdata;
    locked = lvl_q[LVL_W-1];
    // Upper half is sticky: a low-half value is lifted by one half.
    if (locked && !cand[LVL_W-1]) lvl_d = cand | LVL_HALF;
    else                          lvl_d = cand;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= LVL_RST;
    else if (lvl_en) lvl_q <= lvl_d;
  end
endmodule

// File: rtl/ssu_sp_bank.sv
module ssu_sp_bank #(
  parameter int SP_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_q,
  input  logic            sel_d,
  input  logic            sp_we,
  input  logic [SP_W-1:0] sp_wdata,
  input  logic            usp_we,
  input  logic [SP_W-1:0] usp_wdata,
  input  logic            ssp_we,
  input  logic [SP_W-1:0] ssp_wdata,
  output logic [SP_W-1:0] sp_rdata,
  output logic [SP_W-1:0] usp_rdata,
  output logic [SP_W-1:0] ssp_rdata
);
  logic [SP_W-1:0] live_q, live_d;
  logic [SP_W-1:0] usr_q, usr_d;
  logic [SP_W-1:0] sys_q, sys_d;
  logic            live_en, usr_en, sys_en;
  logic            swap;
  logic            alias_we;
  logic [SP_W-1:0] alias_wd;

  always_comb begin
    swap     = sel_q ^ sel_d;
    alias_we = sel_q ? usp_we : ssp_we;
    alias_wd = sel_q ? usp_wdata : ssp_wdata;
    live_en  = 1'b0;
    usr_en   = 1'b0;
    sys_en   = 1'b0;
    live_d   = live_q;
    usr_d    = usr_q;
    sys_d    = sys_q;
    if (swap) begin
      live_en = 1'b1;
      if (sel_q) begin
        usr_en = 1'b1;
        usr_d  = live_q;
        live_d = sys_q;
      end else begin
        sys_en = 1'b1;
        sys_d  = live_q;
        live_d = usr_q;
      end
    end else begin
      if (sp_we) begin
        live_en = 1'b1;
        live_d  = sp_wdata;
      end else if (alias_we) begin
        live_en = 1'b1;
        live_d  = alias_wd;
      end
      if (sel_q && ssp_we) begin
        sys_en = 1'b1;
        sys_d  = ssp_wdata;
      end
      if (!sel_q && usp_we) begin
        usr_en = 1'b1;
        usr_d  = usp_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      usr_q  <= '0;
      sys_q  <= '0;
    end else begin
      if (live_en) live_q <= live_d;
      if (usr_en)  usr_q  <= usr_d;
      if (sys_en)  sys_q  <= sys_d;
    end
  end

  assign sp_rdata  = live_q;
  assign usp_rdata = sel_q ? live_q : usr_q;
  assign ssp_rdata = sel_q ? sys_q  : live_q;
endmodule

// File: rtl/status_stack_unit.sv
module status_stack_unit
  import ssu_pkg::*;
#(
  parameter int SP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [SW_W-1:0]   sw_wdata,
  output logic [SW_W-1:0]   sw_rdata,
  input  logic              cc_we,
  input  logic [BYTE_W-1:0] cc_wdata,
  output logic [BYTE_W-1:0] cc_rdata,
  input  logic              ctl_we,
  input  logic [BYTE_W-1:0] ctl_wdata,
  output logic [BYTE_W-1:0] ctl_rdata,
  input  logic              lvl_we,
  input  logic [LVL_W-1:0]  lvl_wdata,
  input  logic              sp_we,
  input  logic [SP_W-1:0]   sp_wdata,
  output logic [SP_W-1:0]   sp_rdata,
  input  logic              usp_we,
  input  logic [SP_W-1:0]   usp_wdata,
  output logic [SP_W-1:0]   usp_rdata,
  input  logic              ssp_we,
  input  logic [SP_W-1:0]   ssp_wdata,
  output logic [SP_W-1:0]   ssp_rdata
);
  logic [CC_W-1:0]  cc_d, cc_q;
  logic [CTL_W-1:0] ctl_d, ctl_q;
  logic [LVL_W-1:0] lvl_q;
  logic             unused_ctl_d;

  ssu_field #(.W(CC_W), .LSB(0)) u_cc (
    .clk(clk), .rst_n(rst_n),
    .word_we(sw_we), .word_wdata(sw_wdata),
    .byte_we(cc_we), .byte_wdata(cc_wdata),
    .fld_d(cc_d), .fld_q(cc_q)
  );

  ssu_field #(.W(CTL_W), .LSB(CTL_LSB)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .word_we(sw_we), .word_wdata(sw_wdata),
    .byte_we(ctl_we), .byte_wdata(ctl_wdata),
    .fld_d(ctl_d), .fld_q(ctl_q)
  );
  assign unused_ctl_d = ^ctl_d;

  ssu_level u_lvl (
    .clk(clk), .rst_n(rst_n),
    .word_we(sw_we), .word_lvl(sw_wdata[LVL_LSB +: LVL_W]),
    .lvl_we(lvl_we), .lvl_wdata(lvl_wdata),
    .lvl_q(lvl_q)
  );

  ssu_sp_bank #(.SP_W(SP_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .sel_q(cc_q[SEL_BIT]), .sel_d(cc_d[SEL_BIT]),
    .sp_we(sp_we), .sp_wdata(sp_wdata),
    .usp_we(usp_we), .usp_wdata(usp_wdata),
    .ssp_we(ssp_we), .ssp_wdata(ssp_wdata),
    .sp_rdata(sp_rdata), .usp_rdata(usp_rdata), .ssp_rdata(ssp_rdata)
  );

  assign sw_rdata  = pack_word(cc_q, ctl_q, lvl_q);
  assign cc_rdata  = BYTE_W'(cc_q);
  assign ctl_rdata = BYTE_W'(ctl_q);
endmodule

// File: rtl/ssu_checker.sv
module ssu_checker #(
  parameter int SP_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sw_we,
  input logic [31:0]     sw_wdata,
  input logic            cc_we,
  input logic [7:0]      cc_wdata,
  input logic            sp_we,
  input logic            usp_we,
  input logic            ssp_we,
  input logic [31:0]     sw_rdata,
  input logic [7:0]      cc_rdata,
  input logic [SP_W-1:0] sp_rdata,
  input logic [SP_W-1:0] usp_rdata,
  input logic [SP_W-1:0] ssp_rdata
);
  logic cur_sel, new_sel;
  logic unused_chk;

  assign unused_chk = ^{sw_wdata, cc_wdata};
  assign cur_sel = cc_rdata[5];
  assign new_sel = sw_we ? sw_wdata[5] : (cc_we ? cc_wdata[5] : cur_sel);

  p_zero_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rdata[31:21] == '0) && (sw_rdata[15:11] == '0) &&
    (sw_rdata[7:6] == '0) && (cc_rdata == sw_rdata[7:0]));

  p_level_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rdata[20] |=> sw_rdata[20]);

  p_swap_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_sel && new_sel) |=>
      (ssp_rdata == $past(sp_rdata)) && (sp_rdata == $past(usp_rdata)));

  p_swap_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_sel && !new_sel) |=>
      (usp_rdata == $past(sp_rdata)) && (sp_rdata == $past(ssp_rdata)));

  p_no_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_sel == new_sel) && !sp_we && !usp_we && !ssp_we) |=>
      ($stable(sp_rdata) && $stable(usp_rdata) && $stable(ssp_rdata)));

  p_user_alias_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cur_sel |-> (usp_rdata == sp_rdata));

  p_sys_alias_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_sel |-> (ssp_rdata == sp_rdata));
endmodule

bind status_stack_unit ssu_checker #(.SP_W(SP_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .sw_we(sw_we), .sw_wdata(sw_wdata),
  .cc_we(cc_we), .cc_wdata(cc_wdata),
  .sp_we(sp_we), .usp_we(usp_we), .ssp_we(ssp_we),
  .sw_rdata(sw_rdata), .cc_rdata(cc_rdata),
  .sp_rdata(sp_rdata), .usp_rdata(usp_rdata), .ssp_rdata(ssp_rdata)
);

// File: tb/sim_status_stack_unit.sv
module sim_status_stack_unit;
  localparam int SP_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_we = 1'b0, cc_we = 1'b0, ctl_we = 1'b0, lvl_we = 1'b0;
  logic sp_we = 1'b0, usp_we = 1'b0, ssp_we = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [7:0]  cc_wdata = '0, ctl_wdata = '0;
  logic [4:0]  lvl_wdata = '0;
  logic [SP_W-1:0] sp_wdata = '0, usp_wdata = '0, ssp_wdata = '0;
  logic [31:0] sw_rdata;
  logic [7:0]  cc_rdata, ctl_rdata;
  logic [SP_W-1:0] sp_rdata, usp_rdata, ssp_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  logic [5:0] m_cc;
  logic [2:0] m_ctl;
  logic [4:0] m_lvl;
  logic [SP_W-1:0] m_live, m_usr, m_sys;

  always #5 clk = ~clk;

  status_stack_unit #(.SP_W(SP_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .cc_we(cc_we), .cc_wdata(cc_wdata), .cc_rdata(cc_rdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .lvl_we(lvl_we), .lvl_wdata(lvl_wdata),
    .sp_we(sp_we), .sp_wdata(sp_wdata), .sp_rdata(sp_rdata),
    .usp_we(usp_we), .usp_wdata(usp_wdata), .usp_rdata(usp_rdata),
    .ssp_we(ssp_we), .ssp_wdata(ssp_wdata), .ssp_rdata(ssp_rdata)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [4:0] floor_lvl(logic [4:0] cur, logic [4:0] v);
    return (cur >= 5'd16 && v < 5'd16) ? v + 5'd16 : v;
  endfunction

  task automatic compare_all(string tag);
    logic sel;
    sel = m_cc[5];
    chk(tag, "cc_rdata",  32'(cc_rdata),  32'(m_cc));
    chk(tag, "ctl_rdata", 32'(ctl_rdata), 32'(m_ctl));
    chk(tag, "sw_rdata",  sw_rdata, (32'(m_lvl) << 16) | (32'(m_ctl) << 8) | 32'(m_cc));
    chk(tag, "sp_rdata",  sp_rdata, m_live);
    chk(tag, "usp_rdata", usp_rdata, sel ? m_live : m_usr);
    chk(tag, "ssp_rdata", ssp_rdata, sel ? m_sys : m_live);
  endtask

  task automatic model_update();
    logic [5:0] ncc;
    logic old_sel;
    ncc = m_cc;
    old_sel = m_cc[5];
    if (sw_we) begin
      ncc   = sw_wdata[5:0];
      m_ctl = sw_wdata[10:8];
      m_lvl = floor_lvl(m_lvl, sw_wdata[20:16]);
    end else begin
      if (cc_we)  ncc   = cc_wdata[5:0];
      if (ctl_we) m_ctl = ctl_wdata[2:0];
      if (lvl_we) m_lvl = floor_lvl(m_lvl, lvl_wdata);
    end
    if (ncc[5] != old_sel) begin
      if (old_sel) begin m_usr = m_live; m_live = m_sys; end
      else         begin m_sys = m_live; m_live = m_usr; end
    end else begin
      if (sp_we) m_live = sp_wdata;
      else if (old_sel ? usp_we : ssp_we) m_live = old_sel ? usp_wdata : ssp_wdata;
      if (old_sel && ssp_we)  m_sys = ssp_wdata;
      if (!old_sel && usp_we) m_usr = usp_wdata;
    end
    m_cc = ncc;
  endtask

  task automatic clear_we();
    sw_we = 0; cc_we = 0; ctl_we = 0; lvl_we = 0;
    sp_we = 0; usp_we = 0; ssp_we = 0;
  endtask

  // Called at a falling edge with inputs set; returns at the next falling edge.
  task automatic step(string tag);
    model_update();
    @(posedge clk); #1;
    compare_all(tag);
    @(negedge clk);
    clear_we();
  endtask

  task automatic do_reset();
    clear_we();
    rst_n = 0;
    m_cc = '0; m_ctl = '0; m_lvl = 5'd15;
    m_live = '0; m_usr = '0; m_sys = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    do_reset();
    @(posedge clk); #1;
    // R1: reset values
    chk("R1", "sw_rdata", sw_rdata, 32'h000F_0000);
    chk("R1", "sp_rdata", sp_rdata, '0);
    chk("R1", "usp_rdata", usp_rdata, '0);
    chk("R1", "ssp_rdata", ssp_rdata, '0);
    compare_all("R1");
    @(negedge clk);

    // R7 / R9 / R10 / R8 / R11 directed swap sequence
    sp_we = 1; sp_wdata = 32'h1111_0000;
    usp_we = 1; usp_wdata = 32'h0000_2222;
    step("R10");
    cc_we = 1; cc_wdata = 8'h20;
    step("R7");
    chk("R7", "sp after rise", sp_rdata, 32'h0000_2222);
    chk("R7", "ssp after rise", ssp_rdata, 32'h1111_0000);
    cc_we = 1; cc_wdata = 8'h21;
    step("R9");
    chk("R9", "sp same select", sp_rdata, 32'h0000_2222);
    ssp_we = 1; ssp_wdata = 32'h0000_3333;
    usp_we = 1; usp_wdata = 32'h0000_4444;
    step("R10");
    chk("R10", "user alias live", sp_rdata, 32'h0000_4444);
    chk("R10", "sys shadow", ssp_rdata, 32'h0000_3333);
    cc_we = 1; cc_wdata = 8'h00;
    step("R8");
    chk("R8", "usp after fall", usp_rdata, 32'h0000_4444);
    chk("R8", "sp after fall", sp_rdata, 32'h0000_3333);
    cc_we = 1; cc_wdata = 8'h20; sp_we = 1; sp_wdata = 32'hDEAD_BEEF;
    step("R11");
    chk("R11", "swap drops sp write", sp_rdata, 32'h0000_4444);
    sp_we = 1; sp_wdata = 32'h0000_5555; usp_we = 1; usp_wdata = 32'h0000_6666;
    step("R11");
    chk("R11", "sp port wins", sp_rdata, 32'h0000_5555);

    // R12: nothing changes before the edge
    cc_we = 1; cc_wdata = 8'h0F;
    #1;
    chk("R12", "cc before edge", 32'(cc_rdata), 32'h20);
    step("R12");
    chk("R12", "cc after edge", 32'(cc_rdata), 32'h0F);

    // R2: full flag-byte sweep with pointer traffic
    for (int v = 0; v < 256; v++) begin
      cc_we = 1; cc_wdata = 8'(v);
      if (v % 3 == 0) begin sp_we = 1;  sp_wdata  = 32'(v) * 32'h0101_0101; end
      if (v % 5 == 1) begin usp_we = 1; usp_wdata = 32'(v) ^ 32'hA000_0000; end
      if (v % 7 == 2) begin ssp_we = 1; ssp_wdata = 32'(v) ^ 32'h0B00_0000; end
      step("R2");
    end

    // R3: full control-byte sweep
    for (int v = 0; v < 256; v++) begin
      ctl_we = 1; ctl_wdata = 8'(v);
      step("R3");
    end

    // R4 / R5: status-word patterns, some colliding with field writes
    for (int i = 0; i < 16; i++) begin
      sw_we = 1; sw_wdata = (32'(i) * 32'h1357_9BDF) ^ 32'hC3C3_0F0F;
      if (i % 2 == 1) begin
        cc_we = 1; cc_wdata = ~sw_wdata[7:0];
        ctl_we = 1; ctl_wdata = ~sw_wdata[15:8];
        lvl_we = 1; lvl_wdata = ~sw_wdata[20:16];
        step("R5");
      end else begin
        step("R4");
      end
    end

    // R6: level floor over every stored/written pair
    for (int cur = 0; cur < 32; cur++) begin
      for (int nv = 0; nv < 32; nv++) begin
        do_reset();
        if (cur != 15) begin
          lvl_we = 1; lvl_wdata = 5'(cur);
          step("R6");
        end
        if (nv % 2 == 1) begin
          sw_we = 1; sw_wdata = 32'(nv) << 16;
        end else begin
          lvl_we = 1; lvl_wdata = 5'(nv);
        end
        step("R6");
        chk("R6", "level",
            32'(sw_rdata[20:16]),
            32'((cur >= 16 && nv < 16) ? nv + 16 : nv));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule